// File: doc/BRIEF.md
# Speaker Gate and Refresh Status Port

This block is a single byte-wide I/O register for a speaker tone path. A write sets two control bits: the gate of a built-in square-wave tone timer, and a speaker data enable. A read returns those two bits together with the live timer level and a refresh indicator. The refresh indicator changes state on every read of the port. It does not follow a clock, so polling software always sees it move.

The tone timer is a small down counter run by a two-state machine. In `TMR_IDLE` the output sits high. The transition `TMR_IDLE -> TMR_RUN` ("arm") is taken when the machine first sees the gate high; it loads the count from the `tone_reload` input. In `TMR_RUN` the machine either counts down or, on reaching the end of a half period, inverts the output and reloads ("flip"). The transition `TMR_RUN -> TMR_IDLE` ("disarm") is taken when the gate is seen low, and it forces the output high again. The speaker pin is the AND of the data enable and the timer level.

The host reaches the port through a plain bus: address, write strobe, read strobe and a byte in each direction. Read data is registered and keeps its value until the next read of the port.

Top module: `spkp_port`

## Requirements
- R1: Only an access whose `bus_addr` equals `PORT_ADDR` (default 0x0061) reaches the port. A write to any other address changes neither the control bits nor `spk_out`.
- R2: A write to the port stores `bus_wdata[0]` as the timer gate and `bus_wdata[1]` as the data enable, from the clock edge that takes the write. Bits 7..2 of the write data are ignored.
- R3: A read of the port loads `bus_rdata` at the read edge. The byte carries bit 0 = gate, bit 1 = data enable, bit 4 = refresh, bit 5 = timer level, and bits 2, 3, 6 and 7 are zero. `bus_rdata` holds its value between port reads.
- R4: Each port read inverts the refresh bit and returns the inverted value. The first read after reset therefore shows bit 4 = 1.
- R5: A read of any other address leaves both the refresh bit and `bus_rdata` unchanged.
- R6: While `rst_n` is low, the gate, data enable, refresh bit and `bus_rdata` are all zero, the timer is in `TMR_IDLE` with its level high, and `spk_out` is 0.
- R7: `spk_out` is high exactly when the data enable and the timer level are both high.
- R8: One edge after the gate becomes 1, the timer arms. It loads `tone_reload` = N and holds its level high for N cycles, then inverts every N cycles. N = 0 means 2^CNT_W cycles. The reload value is sampled again at every flip.
- R9: One edge after the gate is seen at 0, the timer returns to `TMR_IDLE` with its level high. The next rising gate restarts with a full high half period.
- R10: When a port write and a port read fall in the same cycle, the read returns the control bits as they were before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Access address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| tone_reload | input | CNT_W | Half-period length of the tone timer in cycles |
| spk_out | output | 1 | Speaker drive, data enable AND timer level |

## Verification
The bench targets the half-period boundaries. A counter that is off by one, or that loads one edge late, shifts the first falling edge of `spk_out` and fails the cycle-exact check after the gate rises. It also checks a reload of 1 and a reload of 0, where a design that stalls on zero would never toggle.

The bench lowers the gate while the level is low. A design that keeps the old level, or that waits for a half-period boundary, leaves the speaker silent when it should go high.

It reads addresses next to the port. A decoder that matches only the low address bits would flip the refresh bit there, and the next port read would return the wrong bit 4.

It issues a read and a write in the same cycle, which exposes read data that shows the new control bits when it should show the old ones.

// File: rtl/spkp_pkg.sv
package spkp_pkg;

    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    localparam int CTL_GATE_BIT = 0;
    localparam int CTL_EN_BIT   = 1;

    localparam int STS_GATE_BIT    = 0;
    localparam int STS_EN_BIT      = 1;
    localparam int STS_REFRESH_BIT = 4;
    localparam int STS_TONE_BIT    = 5;

endpackage

// File: rtl/spkp_decode.sv
module spkp_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              wr_hit,
    output logic              rd_hit
);

    logic addr_match;

    always_comb begin
        addr_match = (bus_addr == PORT_ADDR);
        wr_hit     = bus_wr && addr_match;
        rd_hit     = bus_rd && addr_match;
    end

endmodule

// File: rtl/spkp_ctrl.sv
module spkp_ctrl
    import spkp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic       rd_hit,
    input  logic [1:0] ctl_bits,
    input  logic       tone_lvl,
    output logic       gate_q,
    output logic       en_q,
    output logic       refresh_q,
    output logic [7:0] rdata_q
);

    logic [7:0] sts_byte;
    logic       refresh_nxt;

    always_comb begin
        refresh_nxt                = ~refresh_q;
        sts_byte                   = 8'h00;
        sts_byte[STS_GATE_BIT]     = gate_q;
        sts_byte[STS_EN_BIT]       = en_q;
        sts_byte[STS_REFRESH_BIT]  = refresh_nxt;
        sts_byte[STS_TONE_BIT]     = tone_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (wr_hit) begin
            gate_q <= ctl_bits[CTL_GATE_BIT];
            en_q   <= ctl_bits[CTL_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_q <= 1'b0;
            rdata_q   <= 8'h00;
        end else if (rd_hit) begin
            refresh_q <= refresh_nxt;
            rdata_q   <= sts_byte;
        end
    end

endmodule

// File: rtl/spkp_tone_timer.sv
module spkp_tone_timer
    import spkp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic [CNT_W-1:0] reload,
    output logic             tone_lvl
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    tmr_state_e       state_q;
    tmr_state_e       state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == CNT_LAST);

    // next-state selection
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            TMR_IDLE: if (gate)  state_nxt = TMR_RUN;   // arm
            TMR_RUN:  if (!gate) state_nxt = TMR_IDLE;  // disarm
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_nxt;
    end

    // outputs: level and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            tone_lvl <= 1'b1;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    tone_lvl <= 1'b1;
                    if (gate) cnt_q <= reload;
                end
                TMR_RUN: begin
                    if (!gate) begin
                        tone_lvl <= 1'b1;
                    end else if (at_last) begin
                        tone_lvl <= ~tone_lvl;      // flip
                        cnt_q    <= reload;
                    end else begin
                        cnt_q    <= cnt_q - CNT_LAST;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spkp_port.sv
module spkp_port #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061,
    parameter int                CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [CNT_W-1:0]  tone_reload,
    output logic              spk_out
);

    logic wr_hit;
    logic rd_hit;
    logic gate;
    logic data_en;
    logic refresh;
    logic tone_lvl;

    spkp_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    spkp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit),
        .ctl_bits  (bus_wdata[1:0]),
        .tone_lvl  (tone_lvl),
        .gate_q    (gate),
        .en_q      (data_en),
        .refresh_q (refresh),
        .rdata_q   (bus_rdata)
    );

    spkp_tone_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate     (gate),
        .reload   (tone_reload),
        .tone_lvl (tone_lvl)
    );

    assign spk_out = data_en & tone_lvl;

endmodule

// File: rtl/spkp_port_chk.sv
module spkp_port_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              spk_out,
    input logic              gate_q,
    input logic              en_q,
    input logic              refresh_q,
    input logic              tone_lvl
);

    logic hit;
    assign hit = (bus_addr == PORT_ADDR);

    AST_CTL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit) |=> ({6'b0, en_q, gate_q} == ($past(bus_wdata) & 8'h03))); // R2

    AST_REFRESH_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit) |=> (bus_rdata[4] == !$past(refresh_q))); // R4

    AST_NOHIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> ($stable(bus_rdata) && $stable(refresh_q))); // R5

    AST_MUTE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && !bus_wdata[1]) |=> !spk_out); // R7

    AST_ARM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |=> tone_lvl); // R8

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!gate_q) |-> tone_lvl); // R9

endmodule

bind spkp_port spkp_port_chk #(
    .ADDR_W    (ADDR_W),
    .PORT_ADDR (PORT_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .spk_out   (spk_out),
    .gate_q    (gate),
    .en_q      (data_en),
    .refresh_q (refresh),
    .tone_lvl  (tone_lvl)
);

// File: tb/test_spkp_port.sv
module test_spkp_port;

    localparam int          AW   = 16;
    localparam int          CW   = 8;
    localparam logic [15:0] PORT = 16'h0061;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] bus_addr;
    logic          bus_wr;
    logic          bus_rd;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata;
    logic [CW-1:0] tone_reload;
    logic          spk_out;

    always #10 clk = ~clk;   // 50 MHz

    spkp_port #(.ADDR_W(AW), .PORT_ADDR(PORT), .CNT_W(CW)) i_spkp_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tone_reload (tone_reload),
        .spk_out     (spk_out)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       pend = 1'b0;
    logic       ref_exp = 1'b0;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) pend <= rst_n && bus_rd && (bus_addr == PORT);

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected read result", bus_rdata, 8'hxx);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    function automatic logic [7:0] sts(logic g, logic e, logic r, logic t);
        return {2'b00, t, r, 2'b00, e, g};
    endfunction

    function automatic logic tone_exp(int k, int r);
        int eff;
        eff = (r == 0) ? (1 << CW) : r;
        return (((k - 1) / eff) % 2) == 0;
    endfunction

    // all tasks start and end at a negedge
    task automatic wr_port(logic [AW-1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_port(logic [AW-1:0] a, string tag, logic g, logic e, logic t);
        if (a == PORT) begin
            ref_exp = ~ref_exp;
            exp_q.push_back(sts(g, e, ref_exp, t));
            tag_q.push_back(tag);
        end
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rw_port(logic [7:0] d, string tag, logic g, logic e, logic t);
        ref_exp = ~ref_exp;
        exp_q.push_back(sts(g, e, ref_exp, t));
        tag_q.push_back(tag);
        bus_addr = PORT; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic run_check(int r, logic en, int k0, int k1, string tag);
        for (int k = k0; k <= k1; k++) begin
            @(negedge clk);
            chk(tag, {7'b0, spk_out}, {7'b0, en & tone_exp(k, r)});
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = '0; tone_reload = 8'd4;
        repeat (3) @(negedge clk);
        chk("R6 rdata in reset", bus_rdata, 8'h00);
        chk("R6 spk in reset", {7'b0, spk_out}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: refresh toggles per port read
        rd_port(PORT, "R4 first read", 1'b0, 1'b0, 1'b1);
        rd_port(PORT, "R4 second read", 1'b0, 1'b0, 1'b1);
        // R5: neighbour read ignored
        rd_port(16'h0060, "R5", 1'b0, 1'b0, 1'b1);
        chk("R5 rdata held", bus_rdata, 8'h20);
        rd_port(16'h0161, "R5", 1'b0, 1'b0, 1'b1);
        chk("R5 rdata held far", bus_rdata, 8'h20);
        rd_port(PORT, "R5 refresh untouched", 1'b0, 1'b0, 1'b1);

        // R1: write elsewhere ignored
        wr_port(16'h0060, 8'h03);
        chk("R1 spk after foreign write", {7'b0, spk_out}, 8'h00);
        rd_port(PORT, "R1 ctl untouched", 1'b0, 1'b0, 1'b1);

        // R2 / R7
        wr_port(PORT, 8'h02);
        chk("R7 spk enable idle high", {7'b0, spk_out}, 8'h01);
        rd_port(PORT, "R2 enable stored", 1'b0, 1'b1, 1'b1);
        wr_port(PORT, 8'hFC);
        chk("R2 upper bits ignored spk", {7'b0, spk_out}, 8'h00);
        rd_port(PORT, "R2 upper bits ignored", 1'b0, 1'b0, 1'b1);

        // R10: same-cycle write and read
        wr_port(PORT, 8'h02);
        rw_port(8'h00, "R10 read sees old bits", 1'b0, 1'b1, 1'b1);
        chk("R10 write still applied", {7'b0, spk_out}, 8'h00);

        // R8: half period 4, then R9 gate drop while low
        tone_reload = 8'd4;
        wr_port(PORT, 8'h03);
        run_check(4, 1'b1, 1, 14, "R8 reload 4");
        wr_port(PORT, 8'h02);
        chk("R9 level before disarm", {7'b0, spk_out}, 8'h00);
        @(negedge clk);
        chk("R9 idle high after gate low", {7'b0, spk_out}, 8'h01);
        repeat (5) begin
            @(negedge clk);
            chk("R9 idle stays high", {7'b0, spk_out}, 8'h01);
        end

        // R8 half period 3 with a status read while low (R3)
        tone_reload = 8'd3;
        wr_port(PORT, 8'h03);
        run_check(3, 1'b1, 1, 4, "R8 reload 3");
        rd_port(PORT, "R3 running status", 1'b1, 1'b1, 1'b0);
        chk("R8 reload 3 k5", {7'b0, spk_out}, {7'b0, tone_exp(5, 3)});
        run_check(3, 1'b1, 6, 9, "R8 reload 3");

        // R8 reload 1 after restart (R9 restart)
        wr_port(PORT, 8'h02);
        tone_reload = 8'd1;
        wr_port(PORT, 8'h03);
        run_check(1, 1'b1, 1, 6, "R9 restart reload 1");

        // R7 enable low masks tone
        wr_port(PORT, 8'h02);
        tone_reload = 8'd2;
        wr_port(PORT, 8'h01);
        run_check(2, 1'b0, 1, 6, "R7 muted");

        // R8 reload 0 = 256 cycles
        wr_port(PORT, 8'h02);
        tone_reload = 8'd0;
        wr_port(PORT, 8'h03);
        for (int k = 1; k <= 257; k++) begin
            @(negedge clk);
            if (k == 1 || k == 256 || k == 257)
                chk("R8 reload zero", {7'b0, spk_out}, {7'b0, tone_exp(k, 0)});
        end

        // R6 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6 spk after reset", {7'b0, spk_out}, 8'h00);
        chk("R6 rdata after reset", bus_rdata, 8'h00);
        rst_n = 1'b1;
        ref_exp = 1'b0;
        @(negedge clk);
        rd_port(PORT, "R6 state after reset", 1'b0, 1'b0, 1'b1);
        @(negedge clk);

        if (exp_q.size() != 0) chk("R3 reads left pending", 8'(exp_q.size()), 8'h00);
        finish_run();
    end

endmodule